// File: doc/BRIEF.md
# Triggered Acquisition Capture Sequencer

This block sequences a windowed capture for one group of sampling channels in a data acquisition front end. A down-counting pacer divider produces a periodic tick. While a capture runs, each tick that lands in an active window becomes a sample strobe. A state machine first gathers a programmed number of samples ahead of the trigger. It then waits for a start trigger and samples until a stop trigger arrives. After that it gathers a programmed number of trailing samples and finishes.

A 32-bit running sample total advances only in the three windows that store data. It is cleared only by reset, so it keeps accumulating across re-arms. Eight interrupt sources are latched as sticky status bits, and an enable mask gates them onto a single interrupt output. Software uses a simple write/read register port: it programs the divider, the window lengths and the mask, arms and re-arms the capture, and clears status bits by writing ones.

Top module: `acq_capture_seq`

## Requirements
- R1: Pacer. The readable counter (address 2) ticks in every cycle in which it holds 0, then reloads the divide value (address 1) on the next edge. Otherwise it decrements by one. The tick period is therefore divide+1 clocks, and a divide value of 0 ticks on every clock. Both the counter and the divide value reset to 0.
- R2: Register map on wr_addr_i and rd_addr_i:
  - 0: command on write (bit0 = arm); state code in bits [2:0] on read.
  - 1: divide value, 16 bits.
  - 2: divider count, read only.
  - 3: pre-trigger length, 16 bits.
  - 4: post-stop length, 16 bits.
  - 5: sample total, read only.
  - 6: interrupt enable, bits [7:0].
  - 7: interrupt status, read, or write ones to clear.
  Unused read bits are 0.
- R3: State codes: idle=0, pre-fill=1, wait-start=2, sampling=3, post-fill=4, done=5. An arm write in idle enters pre-fill with a cleared window count. When the pre-trigger length is 0 it enters wait-start instead. Arm writes in states 1 to 4 are ignored.
- R4: In pre-fill, each sample strobe counts one. The strobe that reaches the pre-trigger length moves the block to wait-start. A start trigger seen before wait-start is ignored.
- R5: In wait-start, start_i moves the block to sampling. In sampling, stop_i moves it to post-fill, or straight to done when the post-stop length is 0.
- R6: In post-fill, the strobe that reaches the post-stop length moves the block to done.
- R7: A sample strobe is a pacer tick while in pre-fill, sampling or post-fill. The sample total increments by one on each strobe, never changes in any other state, and is not cleared by arming.
- R8: Status bits:
  - bit0: sample strobe.
  - bit1: thresh_i high.
  - bit2: pre-fill completed.
  - bit3: start accepted.
  - bit4: stop accepted.
  - bit5: post-stop window completed (also set on a stop with post-stop length 0).
  - bit6: in done while fifo_empty_i is high.
  - bit7: pacer tick.
- R9: A status bit is set on its event whether or not it is enabled, stays set until a 1 is written to it at address 7, and stays set when its event and the clear fall in the same cycle.
- R10: irq_o is high exactly when some status bit and its enable bit are both 1.
- R11: An arm write in done re-arms the capture exactly as from idle, following R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 32 | Read data (combinational from registers) |
| start_i | input | 1 | Start trigger |
| stop_i | input | 1 | Stop trigger |
| fifo_empty_i | input | 1 | Sample FIFO is empty |
| thresh_i | input | 1 | Channel threshold event |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench aims at several corner cases:
- A start trigger pulsed during pre-fill. A design that honoured it early would skip to sampling.
- A divide value of 0. An off-by-one reload would halve the sample rate.
- A zero pre-trigger or post-stop length. A wrong design would stall in a fill state or raise a spurious window-complete flag.
- A re-arm, which must not clear the sample total.
- A threshold event landing in the same cycle as a clear of its bit. A clear-wins design would lose the flag.
- Enable mask changes while status bits are set. A wrong design would drive irq_o from unmasked bits.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_WAIT = 3'd2,
    ST_SAMP = 3'd3,
    ST_POST = 3'd4,
    ST_DONE = 3'd5
  } acq_state_e;

  localparam int unsigned IRQ_N       = 8;
  localparam int unsigned EV_SAMPLE   = 0;
  localparam int unsigned EV_THRESH   = 1;
  localparam int unsigned EV_PRE_FULL = 2;
  localparam int unsigned EV_START    = 3;
  localparam int unsigned EV_STOP     = 4;
  localparam int unsigned EV_POST_END = 5;
  localparam int unsigned EV_COMPLETE = 6;
  localparam int unsigned EV_TICK     = 7;

  localparam logic [2:0] A_CMD  = 3'd0;
  localparam logic [2:0] A_DIV  = 3'd1;
  localparam logic [2:0] A_DCNT = 3'd2;
  localparam logic [2:0] A_PRE  = 3'd3;
  localparam logic [2:0] A_POST = 3'd4;
  localparam logic [2:0] A_SCNT = 3'd5;
  localparam logic [2:0] A_IEN  = 3'd6;
  localparam logic [2:0] A_ISTS = 3'd7;
endpackage

// File: rtl/acq_pacer.sv
module acq_pacer #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic [DIV_W-1:0] cnt_o,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q == '0);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= div_i;
    else             cnt_q <= cnt_q - 1'b1;
  end

  p_reload_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |=> (cnt_q == $past(div_i)));
  p_count_down_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/acq_fsm.sv
module acq_fsm
  import acq_pkg::*;
#(
  parameter int unsigned WIN_W = 16,
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             arm_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             fifo_empty_i,
  input  logic [WIN_W-1:0] pre_len_i,
  input  logic [WIN_W-1:0] post_len_i,
  output acq_state_e       state_o,
  output logic [CNT_W-1:0] sample_cnt_o,
  output logic             ev_sample_o,
  output logic             ev_pre_full_o,
  output logic             ev_start_o,
  output logic             ev_stop_o,
  output logic             ev_post_end_o,
  output logic             ev_complete_o
);
  acq_state_e       state_q, state_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic [CNT_W-1:0] scnt_q;
  logic [WIN_W:0]   win_inc;
  logic             in_window, strobe;

  assign in_window = (state_q == ST_PRE) || (state_q == ST_SAMP) || (state_q == ST_POST);
  assign strobe    = tick_i && in_window;
  assign win_inc   = {1'b0, win_q} + 1'b1;

  always_comb begin
    state_d       = state_q;
    win_d         = win_q;
    ev_pre_full_o = 1'b0;
    ev_start_o    = 1'b0;
    ev_stop_o     = 1'b0;
    ev_post_end_o = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (arm_i) begin
        win_d   = '0;
        state_d = (pre_len_i == '0) ? ST_WAIT : ST_PRE;
      end
      ST_PRE: if (strobe) begin
        if (win_inc >= {1'b0, pre_len_i}) begin
          state_d       = ST_WAIT;
          ev_pre_full_o = 1'b1;
        end else win_d = win_inc[WIN_W-1:0];
      end
      ST_WAIT: if (start_i) begin
        state_d    = ST_SAMP;
        ev_start_o = 1'b1;
      end
      ST_SAMP: if (stop_i) begin
        ev_stop_o = 1'b1;
        win_d     = '0;
        if (post_len_i == '0) begin
          state_d       = ST_DONE;
          ev_post_end_o = 1'b1;
        end else state_d = ST_POST;
      end
      ST_POST: if (strobe) begin
        if (win_inc >= {1'b0, post_len_i}) begin
          state_d       = ST_DONE;
          ev_post_end_o = 1'b1;
        end else win_d = win_inc[WIN_W-1:0];
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      win_q   <= '0;
      scnt_q  <= '0;
    end else begin
      state_q <= state_d;
      win_q   <= win_d;
      if (strobe) scnt_q <= scnt_q + 1'b1;
    end
  end

  assign state_o       = state_q;
  assign sample_cnt_o  = scnt_q;
  assign ev_sample_o   = strobe;
  assign ev_complete_o = (state_q == ST_DONE) && fifo_empty_i;

  p_hold_total_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_window |=> $stable(scnt_q));
  p_no_early_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PRE) |=> (state_q != ST_SAMP));
  p_post_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POST && !tick_i) |=> (state_q == ST_POST));
  p_arm_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SAMP && !stop_i) |=> (state_q == ST_SAMP));
endmodule

// File: rtl/acq_irq.sv
module acq_irq
  import acq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IRQ_N-1:0] ev_i,
  input  logic [IRQ_N-1:0] clr_i,
  input  logic             en_we_i,
  input  logic [IRQ_N-1:0] en_wdata_i,
  output logic [IRQ_N-1:0] en_o,
  output logic [IRQ_N-1:0] stat_o,
  output logic             irq_o
);
  logic [IRQ_N-1:0] stat_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_i) | ev_i;  // set wins
      if (en_we_i) en_q <= en_wdata_i;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign irq_o  = |(stat_q & en_q);

  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(ev_i)) == $past(ev_i)));
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(clr_i & ~ev_i)) == '0));
  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(stat_q & ~clr_i)) == $past(stat_q & ~clr_i)));
endmodule

// File: rtl/acq_capture_seq.sv
module acq_capture_seq
  import acq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned WIN_W  = 16,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [2:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              fifo_empty_i,
  input  logic              thresh_i,
  output logic              irq_o
);
  logic [DIV_W-1:0] div_q, dcnt;
  logic [WIN_W-1:0] pre_q, post_q;
  logic [CNT_W-1:0] scnt;
  logic [IRQ_N-1:0] ev, clr, en, stat;
  logic             tick, arm;
  acq_state_e       state;

  assign arm = wr_en_i && (wr_addr_i == A_CMD) && wr_data_i[0];
  assign clr = (wr_en_i && (wr_addr_i == A_ISTS)) ? wr_data_i[IRQ_N-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      pre_q  <= '0;
      post_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_DIV)  div_q  <= wr_data_i[DIV_W-1:0];
      if (wr_addr_i == A_PRE)  pre_q  <= wr_data_i[WIN_W-1:0];
      if (wr_addr_i == A_POST) post_q <= wr_data_i[WIN_W-1:0];
    end
  end

  acq_pacer #(.DIV_W(DIV_W)) u_pacer (
    .clk_i, .rst_ni, .div_i(div_q), .cnt_o(dcnt), .tick_o(tick)
  );

  acq_fsm #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_fsm (
    .clk_i, .rst_ni,
    .tick_i        (tick),
    .arm_i         (arm),
    .start_i,
    .stop_i,
    .fifo_empty_i,
    .pre_len_i     (pre_q),
    .post_len_i    (post_q),
    .state_o       (state),
    .sample_cnt_o  (scnt),
    .ev_sample_o   (ev[EV_SAMPLE]),
    .ev_pre_full_o (ev[EV_PRE_FULL]),
    .ev_start_o    (ev[EV_START]),
    .ev_stop_o     (ev[EV_STOP]),
    .ev_post_end_o (ev[EV_POST_END]),
    .ev_complete_o (ev[EV_COMPLETE])
  );

  assign ev[EV_THRESH] = thresh_i;
  assign ev[EV_TICK]   = tick;

  acq_irq u_irq (
    .clk_i, .rst_ni,
    .ev_i       (ev),
    .clr_i      (clr),
    .en_we_i    (wr_en_i && (wr_addr_i == A_IEN)),
    .en_wdata_i (wr_data_i[IRQ_N-1:0]),
    .en_o       (en),
    .stat_o     (stat),
    .irq_o
  );

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_CMD:   rd_data_o[2:0]       = state;
      A_DIV:   rd_data_o[DIV_W-1:0] = div_q;
      A_DCNT:  rd_data_o[DIV_W-1:0] = dcnt;
      A_PRE:   rd_data_o[WIN_W-1:0] = pre_q;
      A_POST:  rd_data_o[WIN_W-1:0] = post_q;
      A_SCNT:  rd_data_o[CNT_W-1:0] = scnt;
      A_IEN:   rd_data_o[IRQ_N-1:0] = en;
      default: rd_data_o[IRQ_N-1:0] = stat;
    endcase
  end

  p_irq_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_IEN && wr_data_i[IRQ_N-1:0] == '0) |=> !irq_o);
  p_stop_leaves_samp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_SAMP && stop_i) |=> (state == ST_POST || state == ST_DONE));
endmodule

// File: tb/tb_acq_capture_seq.sv
`timescale 1ns/10ps
module tb_acq_capture_seq;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        start = 1'b0, stop = 1'b0, fifo_empty = 1'b0, thresh = 1'b0;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  acq_capture_seq dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .start_i(start), .stop_i(stop), .fifo_empty_i(fifo_empty),
    .thresh_i(thresh), .irq_o(irq)
  );

  // behavioural reference model
  int          m_state, m_win, m_div, m_cnt, m_pre, m_post;
  logic [31:0] m_total;
  logic [7:0]  m_stat, m_en;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_state = 0; m_win = 0; m_div = 0; m_cnt = 0; m_pre = 0; m_post = 0;
      m_total = 0; m_stat = 0; m_en = 0;
    end else begin
      bit tick, smp, arm_cmd;
      logic [7:0] ev, clr;
      int ns, nw;
      tick    = (m_cnt == 0);
      smp     = tick && (m_state == 1 || m_state == 3 || m_state == 4);
      arm_cmd = wr_en && wr_addr == 3'd0 && wr_data[0];
      ev = '0;
      ev[7] = tick; ev[0] = smp; ev[1] = thresh;
      if (m_state == 5 && fifo_empty) ev[6] = 1'b1;
      ns = m_state; nw = m_win;
      case (m_state)
        0, 5: if (arm_cmd) begin nw = 0; ns = (m_pre == 0) ? 2 : 1; end
        1: if (smp) begin
             if (m_win + 1 >= m_pre) begin ns = 2; ev[2] = 1'b1; end
             else nw = m_win + 1;
           end
        2: if (start) begin ns = 3; ev[3] = 1'b1; end
        3: if (stop) begin
             ev[4] = 1'b1; nw = 0;
             if (m_post == 0) begin ns = 5; ev[5] = 1'b1; end else ns = 4;
           end
        4: if (smp) begin
             if (m_win + 1 >= m_post) begin ns = 5; ev[5] = 1'b1; end
             else nw = m_win + 1;
           end
        default: ;
      endcase
      if (smp) m_total = m_total + 1;
      m_cnt = tick ? m_div : m_cnt - 1;
      clr = (wr_en && wr_addr == 3'd7) ? wr_data[7:0] : 8'h00;
      m_stat = (m_stat & ~clr) | ev;
      if (wr_en) begin
        case (wr_addr)
          3'd1: m_div  = int'(wr_data[15:0]);
          3'd3: m_pre  = int'(wr_data[15:0]);
          3'd4: m_post = int'(wr_data[15:0]);
          3'd6: m_en   = wr_data[7:0];
          default: ;
        endcase
      end
      m_state = ns; m_win = nw;
    end
  end

  function automatic logic [31:0] exp_rd(int a);
    case (a)
      0: return 32'(m_state);
      1: return 32'(m_div);
      2: return 32'(m_cnt);
      3: return 32'(m_pre);
      4: return 32'(m_post);
      5: return m_total;
      6: return {24'h0, m_en};
      default: return {24'h0, m_stat};
    endcase
  endfunction

  function automatic string req_of(int a);
    case (a)
      0: return "R3/R4/R5/R6/R11 state";
      1: return "R2 divide";
      2: return "R1 divider count";
      3: return "R2 pre length";
      4: return "R2 post length";
      5: return "R7 sample total";
      6: return "R2 enable";
      default: return "R8/R9 status";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, got, exp);
    end
  endtask

  // compare every readable register and irq on every falling edge
  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      for (int a = 0; a < 8; a++) begin
        rd_addr = 3'(a);
        #0.2;
        chk(req_of(a), rd_data, exp_rd(a));
      end
      chk("R10 irq", {31'h0, irq}, {31'h0, |(m_stat & m_en)});
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #3;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1; step(1); start = 1'b0;
  endtask

  task automatic pulse_stop();
    stop = 1'b1; step(1); stop = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(3);                       // R1: divide 0 ticks every clock from reset
    wr(3'd1, 32'd3);
    wr(3'd3, 32'd2);
    wr(3'd4, 32'd3);
    wr(3'd6, 32'h0000_003C);
    wr(3'd0, 32'd1);               // R3 arm from idle
    pulse_start();                 // R4 start ignored in pre-fill
    step(12);
    wr(3'd0, 32'd1);               // R3 arm ignored in wait-start
    pulse_start();                 // R5
    step(9);
    wr(3'd0, 32'd1);               // R3 arm ignored while sampling
    step(2);
    pulse_stop();                  // R5 -> post-fill
    step(18);                      // R6 -> done
    fifo_empty = 1'b1;
    step(3);
    wr(3'd7, 32'hFF);              // R9 complete bit re-set while condition holds
    fifo_empty = 1'b0;
    wr(3'd7, 32'hFF);
    step(1);
    thresh = 1'b1;                 // R9 set wins over same-cycle clear
    wr(3'd7, 32'h02);
    thresh = 1'b0;
    wr(3'd6, 32'h00);              // R10 mask everything
    step(2);
    wr(3'd6, 32'h02);
    step(1);
    wr(3'd3, 32'd0);
    wr(3'd1, 32'd0);               // R1 divide 0 strobes every clock
    wr(3'd0, 32'd1);               // R11 re-arm from done, R3 zero pre -> wait
    step(2);
    pulse_start();
    step(5);                       // R7 total keeps counting after re-arm
    wr(3'd4, 32'd0);
    pulse_stop();                  // R5 zero post -> done directly
    step(3);
    wr(3'd3, 32'd4);
    wr(3'd1, 32'd1);
    wr(3'd6, 32'hFF);
    wr(3'd0, 32'd1);               // R11 re-arm into pre-fill
    step(12);
    thresh = 1'b1; step(1); thresh = 1'b0;
    pulse_start();
    step(4);
    wr(3'd4, 32'd1);
    pulse_stop();
    step(6);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule